// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Core

This block is a minimal processor cut into two stages that run side by side. The fetch stage reads an internal instruction memory at its program counter. Whenever the instruction queue between the stages has room, it pushes the instruction together with its address and steps the counter by one. The execute stage takes the queue head and retires one instruction per cycle against an eight-entry register file and an internal data memory. A branch-if-zero that is taken writes its target into the program counter and empties the queue, which discards any instructions fetched down the wrong path.

Before a run, both memories are filled through a word loader while `run` is low. After `run` rises, fetch starts at address 0. Each retired instruction is reported on a registered retire trace one cycle after it executes. The trace gives its address, any register write, any memory store and any redirect. The fetch and execute actions are independent guarded actions linked only through the queue. When a taken branch and a fetch fire in the same cycle, the result equals the fetch followed by the branch: the branch's counter write and queue clear take precedence.

Top module: `fe_ex_core`

## Requirements
- R1: After reset the trace is idle (`cmt_valid` low), all eight registers read as zero, and the first instruction retired after `run` rises is the one at address 0.
- R2: The 16-bit instruction encoding is: opcode in bits 15:14, rd in bits 13:11, rs in bits 10:8, rt in bits 7:5, and branch target in bits 7:0. Opcode 00 is add, which writes rs+rt (mod 2^16) into rd.
- R3: While `run` is high and the queue is not full, fetch pushes the instruction at the program counter and advances the counter by one. In straight-line code, consecutive retires have consecutive addresses.
- R4: Opcode 10 is load. It writes the data-memory word at address rs[7:0] into rd.
- R5: Opcode 11 is store. It writes rt into data memory at address rs[7:0] and changes no register.
- R6: Opcode 01 (branch-if-zero) with a nonzero rs only retires itself. It writes no register and no memory, does not redirect, and the next retire is the following address.
- R7: Branch-if-zero with rs equal to zero sets the program counter to the target, empties the queue, and reports the redirect and target on the trace.
- R8: When a taken branch and a fetch fire in the same cycle, the instruction fetched that cycle is dropped. The next retired instruction is the branch target, and the retire stream matches sequential execution.
- R9: Once the pipeline has filled, straight-line instructions retire in back-to-back cycles.
- R10: A taken branch is followed by exactly one cycle with no retire before the target retires.

Before the table, one line on the trace fields: the store fields (`cmt_mem_addr`, `cmt_mem_val`) are meaningful only when `cmt_mem_we` is high, and `cmt_target` only when `cmt_redirect` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables fetch and execute |
| ld_we | input | 1 | Loader write strobe, honoured only while run is low |
| ld_dmem | input | 1 | Loader target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Loader word address |
| ld_data | input | 16 | Loader word |
| cmt_valid | output | 1 | An instruction retired in the previous cycle |
| cmt_pc | output | 8 | Address of the retired instruction |
| cmt_rd_we | output | 1 | Retired instruction wrote a register |
| cmt_rd | output | 3 | Register written |
| cmt_rd_val | output | 16 | Value written |
| cmt_mem_we | output | 1 | Retired instruction stored to data memory |
| cmt_mem_addr | output | 8 | Store address |
| cmt_mem_val | output | 16 | Stored value |
| cmt_redirect | output | 1 | Retired instruction was a taken branch |
| cmt_target | output | 8 | Branch target of a taken branch |

## Verification
Fetching a wrong-path instruction and retiring a taken branch land in the same cycle every time a branch is taken, because the queue holds one entry in steady state. A loop program makes this happen repeatedly, once per back-edge, at the loop exit and in a self-looping halt. The bench runs the same program on a sequential instruction-set model and compares every retire record in order. The redirect is judged correct when the next retired address is the target, never the dropped fall-through address, and when exactly one empty cycle separates the two retires.

// File: rtl/fe_ex_pkg.sv
package fe_ex_pkg;

    localparam int XLEN = 16;
    localparam int AW   = 8;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);
    localparam int MEM_WORDS = 1 << AW;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_BZ  = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e         op;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [4:0]      spare;
    } insn_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        insn_t         insn;
    } slot_t;

    typedef struct packed {
        logic            valid;
        logic [AW-1:0]   pc;
        logic            rd_we;
        logic [RIDX-1:0] rd;
        logic [XLEN-1:0] rd_val;
        logic            mem_we;
        logic [AW-1:0]   mem_addr;
        logic [XLEN-1:0] mem_val;
        logic            redirect;
        logic [AW-1:0]   target;
    } retire_t;

    function automatic logic [AW-1:0] branch_target(insn_t i);
        return {i.rt, i.spare};
    endfunction

    function automatic logic writes_reg(opcode_e op);
        return (op == OP_ADD) || (op == OP_LD);
    endfunction

endpackage

// File: rtl/fetch_stage.sv
module fetch_stage
    import fe_ex_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic            full_i,
    input  logic            redirect_i,
    input  logic [AW-1:0]   redirect_pc_i,
    input  logic            ld_we_i,
    input  logic [AW-1:0]   ld_addr_i,
    input  logic [XLEN-1:0] ld_data_i,
    output logic            push_o,
    output slot_t           slot_o
);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [AW-1:0]   pc_q;

    always_ff @(posedge clk) begin
        if (ld_we_i) imem[ld_addr_i] <= ld_data_i;
    end

    assign push_o = run_i && !full_i;

    always_comb begin
        slot_o.pc   = pc_q;
        slot_o.insn = insn_t'(imem[pc_q]);
    end

    // the redirect is applied after the fetch step, so it overrides it
    always_ff @(posedge clk) begin
        if (rst)             pc_q <= '0;
        else if (redirect_i) pc_q <= redirect_pc_i;
        else if (push_o)     pc_q <= pc_q + 1'b1;
    end

    p_pc_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (push_o && !redirect_i) |=> pc_q == $past(pc_q) + 1'b1);

    p_pc_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> pc_q == $past(redirect_pc_i));

endmodule

// File: rtl/insn_fifo.sv
module insn_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = store_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_q] <= din_i;
    end

    // a clear discards everything, including a push in the same cycle
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    p_push_grows_r3: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o && !pop_i && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> empty_o);

endmodule

// File: rtl/reg_file.sv
module reg_file #(
    parameter int NR = 8,
    parameter int W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [$clog2(NR)-1:0] ra_i,
    input  logic [$clog2(NR)-1:0] rb_i,
    output logic [W-1:0]          ra_o,
    output logic [W-1:0]          rb_o,
    input  logic                  we_i,
    input  logic [$clog2(NR)-1:0] wa_i,
    input  logic [W-1:0]          wd_i
);

    localparam int IW = $clog2(NR);

    logic [W-1:0] regs_q [NR];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rst)                             regs_q[i] <= '0;
            else if (we_i && wa_i == IW'(i))     regs_q[i] <= wd_i;
        end
    end

    assign ra_o = regs_q[ra_i];
    assign rb_o = regs_q[rb_i];

endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import fe_ex_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic            empty_i,
    input  slot_t           head_i,
    input  logic            ld_we_i,
    input  logic [AW-1:0]   ld_addr_i,
    input  logic [XLEN-1:0] ld_data_i,
    output logic            pop_o,
    output logic            redirect_o,
    output logic [AW-1:0]   redirect_pc_o,
    output retire_t         retire_o
);

    insn_t           ins;
    logic            fire, taken, st_we, rf_we;
    logic [XLEN-1:0] rs_val, rt_val, wb_val, mem_rdata;
    logic [AW-1:0]   mem_addr;
    logic [XLEN-1:0] dmem [MEM_WORDS];
    retire_t         ret_d, ret_q;

    assign ins   = head_i.insn;
    assign fire  = run_i && !empty_i;
    assign pop_o = fire;

    reg_file #(.NR(NREG), .W(XLEN)) i_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_i (ins.rs),
        .rb_i (ins.rt),
        .ra_o (rs_val),
        .rb_o (rt_val),
        .we_i (rf_we),
        .wa_i (ins.rd),
        .wd_i (wb_val)
    );

    assign mem_addr  = rs_val[AW-1:0];
    assign mem_rdata = dmem[mem_addr];
    assign wb_val    = (ins.op == OP_LD) ? mem_rdata : rs_val + rt_val;
    assign rf_we     = fire && writes_reg(ins.op);
    assign st_we     = fire && (ins.op == OP_ST);
    assign taken     = fire && (ins.op == OP_BZ) && (rs_val == '0);

    assign redirect_o    = taken;
    assign redirect_pc_o = branch_target(ins);

    always_ff @(posedge clk) begin
        if (st_we)        dmem[mem_addr]  <= rt_val;
        else if (ld_we_i) dmem[ld_addr_i] <= ld_data_i;
    end

    always_comb begin
        ret_d       = '0;
        ret_d.valid = fire;
        if (fire) begin
            ret_d.pc = head_i.pc;
            unique case (ins.op)
                OP_ADD, OP_LD: begin
                    ret_d.rd_we  = 1'b1;
                    ret_d.rd     = ins.rd;
                    ret_d.rd_val = wb_val;
                end
                OP_ST: begin
                    ret_d.mem_we   = 1'b1;
                    ret_d.mem_addr = mem_addr;
                    ret_d.mem_val  = rt_val;
                end
                OP_BZ: begin
                    ret_d.redirect = taken;
                    ret_d.target   = taken ? branch_target(ins) : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ret_q <= '0;
        else     ret_q <= ret_d;
    end

    assign retire_o = ret_q;

    p_nottaken_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ins.op == OP_BZ && rs_val != '0)
        |=> (ret_q.valid && !ret_q.redirect && !ret_q.rd_we && !ret_q.mem_we));

    p_taken_reported_r7: assert property (@(posedge clk) disable iff (rst)
        taken |=> (ret_q.redirect && ret_q.target == $past(redirect_pc_o)));

    p_store_no_regwrite_r5: assert property (@(posedge clk) disable iff (rst)
        st_we |=> (ret_q.mem_we && !ret_q.rd_we));

    p_idle_no_retire_r9: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !ret_q.valid);

endmodule

// File: rtl/fe_ex_core.sv
module fe_ex_core
    import fe_ex_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        ld_we,
    input  logic        ld_dmem,
    input  logic [7:0]  ld_addr,
    input  logic [15:0] ld_data,
    output logic        cmt_valid,
    output logic [7:0]  cmt_pc,
    output logic        cmt_rd_we,
    output logic [2:0]  cmt_rd,
    output logic [15:0] cmt_rd_val,
    output logic        cmt_mem_we,
    output logic [7:0]  cmt_mem_addr,
    output logic [15:0] cmt_mem_val,
    output logic        cmt_redirect,
    output logic [7:0]  cmt_target
);

    localparam int SLOT_W = $bits(slot_t);

    logic              ld_go, imem_we, dmem_we;
    logic              push, pop, full, empty, redirect;
    logic [AW-1:0]     redirect_pc;
    slot_t             fetch_slot, head_slot;
    logic [SLOT_W-1:0] fifo_din, fifo_dout;
    retire_t           ret;

    assign ld_go   = ld_we && !run;
    assign imem_we = ld_go && !ld_dmem;
    assign dmem_we = ld_go && ld_dmem;

    fetch_stage i_fetch (
        .clk           (clk),
        .rst           (rst),
        .run_i         (run),
        .full_i        (full),
        .redirect_i    (redirect),
        .redirect_pc_i (redirect_pc),
        .ld_we_i       (imem_we),
        .ld_addr_i     (ld_addr),
        .ld_data_i     (ld_data),
        .push_o        (push),
        .slot_o        (fetch_slot)
    );

    assign fifo_din  = fetch_slot;
    assign head_slot = slot_t'(fifo_dout);

    insn_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (redirect),
        .push_i  (push),
        .din_i   (fifo_din),
        .pop_i   (pop),
        .dout_o  (fifo_dout),
        .empty_o (empty),
        .full_o  (full)
    );

    exec_stage i_exec (
        .clk           (clk),
        .rst           (rst),
        .run_i         (run),
        .empty_i       (empty),
        .head_i        (head_slot),
        .ld_we_i       (dmem_we),
        .ld_addr_i     (ld_addr),
        .ld_data_i     (ld_data),
        .pop_o         (pop),
        .redirect_o    (redirect),
        .redirect_pc_o (redirect_pc),
        .retire_o      (ret)
    );

    assign cmt_valid    = ret.valid;
    assign cmt_pc       = ret.pc;
    assign cmt_rd_we    = ret.rd_we;
    assign cmt_rd       = ret.rd;
    assign cmt_rd_val   = ret.rd_val;
    assign cmt_mem_we   = ret.mem_we;
    assign cmt_mem_addr = ret.mem_addr;
    assign cmt_mem_val  = ret.mem_val;
    assign cmt_redirect = ret.redirect;
    assign cmt_target   = ret.target;

endmodule

// File: tb/test_fe_ex_core.sv
module test_fe_ex_core;

    localparam int NCOMMIT = 45;
    localparam int WD_LIMIT = 3000;

    logic        clk = 1'b0;
    logic        rst, run, ld_we, ld_dmem;
    logic [7:0]  ld_addr;
    logic [15:0] ld_data;
    logic        cmt_valid, cmt_rd_we, cmt_mem_we, cmt_redirect;
    logic [7:0]  cmt_pc, cmt_mem_addr, cmt_target;
    logic [2:0]  cmt_rd;
    logic [15:0] cmt_rd_val, cmt_mem_val;

    always #5 clk = ~clk;

    fe_ex_core i_fe_ex_core (
        .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .cmt_valid(cmt_valid), .cmt_pc(cmt_pc), .cmt_rd_we(cmt_rd_we),
        .cmt_rd(cmt_rd), .cmt_rd_val(cmt_rd_val), .cmt_mem_we(cmt_mem_we),
        .cmt_mem_addr(cmt_mem_addr), .cmt_mem_val(cmt_mem_val),
        .cmt_redirect(cmt_redirect), .cmt_target(cmt_target)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  pc;
        logic        rd_we;
        logic [2:0]  rd;
        logic [15:0] rd_val;
        logic        mem_we;
        logic [7:0]  mem_addr;
        logic [15:0] mem_val;
        logic        redirect;
        logic [7:0]  target;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] m_imem [256];
    logic [15:0] m_dmem [256];
    logic [15:0] m_reg  [8];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ncommit = 0;
    int last_cyc = 0;
    bit prev_taken = 0;
    bit running = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // instruction encoders, field positions as given in R2
    function automatic logic [15:0] i_add(int rd, int rs, int rt);
        return {2'b00, 3'(rd), 3'(rs), 3'(rt), 5'b0};
    endfunction
    function automatic logic [15:0] i_bz(int rs, int tgt);
        return {2'b01, 3'b0, 3'(rs), 8'(tgt)};
    endfunction
    function automatic logic [15:0] i_ld(int rd, int rs);
        return {2'b10, 3'(rd), 3'(rs), 8'b0};
    endfunction
    function automatic logic [15:0] i_st(int rt, int rs);
        return {2'b11, 3'b0, 3'(rs), 3'(rt), 5'b0};
    endfunction

    task automatic put_word(input bit to_dmem, input int addr, input logic [15:0] w);
        ld_we   = 1'b1;
        ld_dmem = to_dmem;
        ld_addr = 8'(addr);
        ld_data = w;
        if (to_dmem) m_dmem[addr] = w;
        else         m_imem[addr] = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // sequential instruction-set model: one atomic step per instruction
    task automatic ref_step(inout logic [7:0] pc, output exp_t e);
        logic [15:0] w;
        logic [2:0]  rd, rs, rt;
        logic [7:0]  a;
        w  = m_imem[pc];
        rd = w[13:11];
        rs = w[10:8];
        rt = w[7:5];
        a  = m_reg[rs][7:0];
        e  = '0;
        e.op = w[15:14];
        e.pc = pc;
        pc = pc + 8'd1;
        case (w[15:14])
            2'b00: begin
                e.rd_we = 1'b1; e.rd = rd; e.rd_val = m_reg[rs] + m_reg[rt];
                m_reg[rd] = e.rd_val;
            end
            2'b01: begin
                if (m_reg[rs] == 16'd0) begin
                    e.redirect = 1'b1; e.target = w[7:0]; pc = w[7:0];
                end
            end
            2'b10: begin
                e.rd_we = 1'b1; e.rd = rd; e.rd_val = m_dmem[a];
                m_reg[rd] = e.rd_val;
            end
            default: begin
                e.mem_we = 1'b1; e.mem_addr = a; e.mem_val = m_reg[rt];
                m_dmem[a] = m_reg[rt];
            end
        endcase
    endtask

    task automatic driver();
        logic [7:0] pc;
        exp_t e;
        for (int i = 0; i < 256; i++) begin
            m_imem[i] = 16'd0;
            m_dmem[i] = 16'd0;
        end
        for (int i = 0; i < 8; i++) m_reg[i] = 16'd0;
        put_word(1, 0, 16'd1);
        put_word(1, 1, 16'hFFFF);
        put_word(1, 2, 16'd5);
        put_word(0, 0,  i_ld(5, 0));
        put_word(0, 1,  i_ld(2, 5));
        put_word(0, 2,  i_add(6, 5, 5));
        put_word(0, 3,  i_ld(1, 6));
        put_word(0, 4,  i_add(3, 3, 1));
        put_word(0, 5,  i_st(3, 1));
        put_word(0, 6,  i_add(1, 1, 2));
        put_word(0, 7,  i_bz(1, 9));
        put_word(0, 8,  i_bz(0, 4));
        put_word(0, 9,  i_ld(7, 5));
        put_word(0, 10, i_add(4, 7, 3));
        put_word(0, 11, i_st(4, 0));
        put_word(0, 12, i_bz(0, 12));
        pc = 8'd0;
        for (int n = 0; n < NCOMMIT; n++) begin
            ref_step(pc, e);
            exp_q.push_back(e);
        end
    endtask

    function automatic string tag_of(exp_t e);
        case (e.op)
            2'b00:   return "R2";
            2'b01:   return e.redirect ? "R7" : "R6";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // monitor: compares each retire with the oldest expected record
    always @(negedge clk) begin
        if (running && cmt_valid && ncommit < NCOMMIT) begin
            exp_t  e;
            string t;
            if (exp_q.size() == 0) begin
                check(0, "R8", "unexpected retire", 32'(cmt_pc), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_of(e);
                if (ncommit == 0)
                    check(cmt_pc == e.pc, "R1", "first retired pc", 32'(cmt_pc), 32'(e.pc));
                else if (prev_taken)
                    check(cmt_pc == e.pc, "R8", "pc after taken branch", 32'(cmt_pc), 32'(e.pc));
                else
                    check(cmt_pc == e.pc, (e.op == 2'b01) ? "R6" : "R3", "sequential pc",
                          32'(cmt_pc), 32'(e.pc));
                check(cmt_rd_we == e.rd_we, t, "register write flag", 32'(cmt_rd_we), 32'(e.rd_we));
                if (e.rd_we) begin
                    check(cmt_rd == e.rd, t, "dest register", 32'(cmt_rd), 32'(e.rd));
                    check(cmt_rd_val == e.rd_val, t, "dest value", 32'(cmt_rd_val), 32'(e.rd_val));
                end
                check(cmt_mem_we == e.mem_we, t, "store flag", 32'(cmt_mem_we), 32'(e.mem_we));
                if (e.mem_we) begin
                    check(cmt_mem_addr == e.mem_addr, "R5", "store address",
                          32'(cmt_mem_addr), 32'(e.mem_addr));
                    check(cmt_mem_val == e.mem_val, "R5", "store value",
                          32'(cmt_mem_val), 32'(e.mem_val));
                end
                check(cmt_redirect == e.redirect, t, "redirect flag",
                      32'(cmt_redirect), 32'(e.redirect));
                if (e.redirect)
                    check(cmt_target == e.target, "R7", "branch target",
                          32'(cmt_target), 32'(e.target));
                if (ncommit > 0 && ncommit < 3)
                    check(cyc == last_cyc + 1, "R9", "back-to-back retire",
                          32'(cyc - last_cyc), 32'd1);
                if (prev_taken)
                    check(cyc == last_cyc + 2, "R10", "single bubble after taken branch",
                          32'(cyc - last_cyc), 32'd2);
                prev_taken = e.redirect;
            end
            last_cyc = cyc;
            ncommit  = ncommit + 1;
        end
    end

    initial begin
        int guard;
        rst = 1'b1; run = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0;
        ld_addr = 8'd0; ld_data = 16'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(cmt_valid == 1'b0, "R1", "idle trace after reset", 32'(cmt_valid), 0);
        end
        driver();
        @(negedge clk);
        running = 1'b1;
        run = 1'b1;
        guard = 0;
        while (ncommit < NCOMMIT && guard < WD_LIMIT) begin
            @(negedge clk);
            guard++;
        end
        if (ncommit < NCOMMIT)
            check(0, "R9", "watchdog expired, retires seen", 32'(ncommit), 32'(NCOMMIT));
        check(exp_q.size() == 0, "R8", "expected records left", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule